// File: doc/BRIEF.md
# Resonant-Band Switching Request Suppressor

This block sits between the path that asks for a new conduction cycle and the strobe that fires the primary gate driver. It keeps the effective switching rate out of a frequency band in which the mechanical parts of a converter tend to ring audibly. A band of 5 kHz to 12 kHz maps to a forbidden spacing of roughly 83 µs to 200 µs after a conduction cycle. The block counts clock ticks from the most recent accepted cycle. A request that arrives while that count lies inside the forbidden window is dropped and flagged. Any other request becomes a one-clock drive strobe and restarts the count.

Both window limits are parameters given in clock ticks. At a 50 MHz clock the defaults of 4150 and 10000 ticks match 83 µs and 200 µs. The counter saturates rather than wraps, so a long quiet spell always counts as outside the window. The counter comes out of reset saturated.

Top module: `resonant_band_gate`

## Requirements
- R1: While reset is held, both outputs are low. The first request after reset is always accepted, because the elapsed count starts at its saturated value.
- R2: Elapsed time E is the number of rising clock edges from the edge that accepted the last request to the edge that samples the current request. A request with E < BAND_LO is accepted. drive_o is high for exactly the one clock that follows the sampling edge.
- R3: A request with BAND_LO <= E <= BAND_HI (both limits inclusive) is suppressed. drive_o stays low, and supp_o is high for exactly the one clock that follows the sampling edge.
- R4: A request with E > BAND_HI is accepted in the same way as in R2.
- R5: An accepted request restarts the elapsed count. A request held high on consecutive clocks is judged on each edge against the most recent acceptance.
- R6: A suppressed request does not restart the count. Later requests are still measured from the last accepted one.
- R7: The elapsed count saturates at 2^W-1, where W = clog2(BAND_HI+2), and never wraps. A request after any idle length longer than BAND_HI is accepted.
- R8: drive_o and supp_o are never high in the same clock, and each of them pulses only in response to a sampled request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request for a conduction cycle, sampled on each rising edge |
| drive_o | output | 1 | One-clock gate-drive strobe for an accepted request |
| supp_o | output | 1 | One-clock flag for a request dropped inside the band |

## Verification
Two things can fall in one cycle. A request can arrive exactly as the elapsed count crosses a window limit, and the restart of the count can coincide with the count reaching saturation. The bench places requests at E = BAND_LO-1, BAND_LO, BAND_HI and BAND_HI+1. It also places requests on the tick where the counter saturates and on the tick after it, and it holds the request high across the whole window. A behavioural model keeps an absolute timestamp of the last acceptance and has no saturating counter. It predicts both outputs on every clock, and any disagreement is reported.

// File: rtl/resonant_band_gate.sv
module resonant_band_gate #(
  parameter int BAND_LO = 4150,
  parameter int BAND_HI = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic drive_o,
  output logic supp_o
);

  localparam int CW = $clog2(BAND_HI + 2);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] LO_C = CW'(BAND_LO);
  localparam logic [CW-1:0] HI_C = CW'(BAND_HI);

  logic [CW-1:0] elapsed;
  logic in_band, take, block;

  assign in_band = (elapsed >= LO_C) && (elapsed <= HI_C);
  assign take    = req_i & ~in_band;
  assign block   = req_i &  in_band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= CMAX;
      drive_o <= 1'b0;
      supp_o  <= 1'b0;
    end else begin
      drive_o <= take;
      supp_o  <= block;
      if (take)
        elapsed <= CW'(1);
      else if (elapsed != CMAX)
        elapsed <= elapsed + 1'b1;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_o, supp_o}));

  a_r2_drive_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> $past(req_i));

  a_r3_supp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    supp_o |-> $past(req_i));

  a_r3_band_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && elapsed >= LO_C && elapsed <= HI_C) |=> !drive_o);

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> (elapsed == CW'(1)));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    supp_o |-> (elapsed == CW'($past(elapsed) + 1'b1)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed == CMAX && !req_i) |=> (elapsed == CMAX));

endmodule

// File: tb/resonant_band_gate_bench.sv
module resonant_band_gate_bench;
  localparam int LO = 20;
  localparam int HI = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic drive_o, supp_o;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  resonant_band_gate #(.BAND_LO(LO), .BAND_HI(HI)) u_resonant_band_gate (
    .clk(clk), .rst_n(rst_n), .req_i(req), .drive_o(drive_o), .supp_o(supp_o));

  always #10 clk = ~clk;

  longint cyc = 0;
  longint last_acc = 0;
  bit have_acc = 0;
  bit exp_d = 0, exp_s = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_acc <= 0; exp_d <= 0; exp_s <= 0; cyc <= 0;
    end else begin
      longint e;
      e = have_acc ? (cyc - last_acc) : 64'd1_000_000;
      exp_d <= 0; exp_s <= 0;
      if (req) begin
        if (e >= LO && e <= HI) exp_s <= 1;
        else begin exp_d <= 1; last_acc <= cyc; have_acc <= 1; end
      end
      cyc <= cyc + 1;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("drive_o", drive_o, exp_d);
    chk("supp_o", supp_o, exp_s);
  end

  task automatic req_after(int k);
    for (int i = 0; i < k - 1; i++) begin req = 0; @(negedge clk); end
    req = 1; @(negedge clk); req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin req = 0; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tag = "R1";
    req = 1;
    repeat (3) @(negedge clk);
    chk("reset drive_o", drive_o, 1'b0);
    chk("reset supp_o", supp_o, 1'b0);
    req = 0;
    rst_n = 1;
    idle(2);
    req_after(1);            // R1 first request accepted
    tag = "R2"; req_after(3);
    tag = "R2"; req_after(LO - 1);
    tag = "R3"; req_after(LO);
    tag = "R6"; req_after(10);
    tag = "R4"; req_after(21);
    tag = "R3"; req_after(HI);
    tag = "R4"; req_after(1);
    tag = "R7"; idle(200); req_after(1);
    tag = "R7"; req_after(63);
    tag = "R7"; req_after(64);
    tag = "R5";
    req = 1;
    for (int i = 0; i < 120; i++) @(negedge clk);
    req = 0;
    tag = "R8"; idle(5);
    req_after(HI + 1);
    req_after(LO + 5);
    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule